// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block sits next to the receive and transmit FIFOs of a 16-entry UART and raises one DMA request line for each direction. The receive request is raised when the receive FIFO has collected at least a programmed number of characters, or when a character time-out pulse arrives while fewer characters are waiting. The transmit request is raised on the cycle after the transmit FIFO leaves the full state. Once a request is raised it stays high until the DMA controller pulses the clear strobe for that direction. If the triggering condition goes away, the request does not drop.

The requests are produced only when both the FIFO enable and the DMA mode control bits are 1. Clearing either bit drops both requests and discards anything pending. The same threshold comparison that drives the receive request also drives a receive data-available interrupt condition. That condition needs only the FIFO enable bit.

Top module: `uart_dma_req_gen`

## Requirements
- R1: The 2-bit trigger code selects the receive threshold: code 0 selects 1 character, 1 selects 4, 2 selects 8 and 3 selects 14. `rx_data_avail_o` is high, combinationally, exactly when `fifo_en_i` is 1 and `rx_level_i` is at or above the threshold.
- R2: While enabled, a receive level at or above the threshold makes `rx_dma_req_o` high from the next clock edge.
- R3: While enabled, a one-cycle `rx_timeout_i` pulse makes `rx_dma_req_o` high from the next clock edge, even when the level is below the threshold.
- R4: While enabled, `tx_dma_req_o` goes high on the clock edge after the one where `tx_full_i` goes from 1 to 0.
- R5: If `tx_full_i` stays 0, stays 1 or rises, `tx_dma_req_o` does not set.
- R6: A raised request stays high until its clear strobe arrives, even after its set condition has gone away.
- R7: A clear strobe with no set condition in the same cycle drives the request low at the next clock edge.
- R8: If a set condition and the clear strobe occur in the same cycle, the request is 1 after the edge.
- R9: When `fifo_en_i` or `dma_mode_i` is 0, both requests are low after the next edge. A request that was pending before does not return when the block is enabled again.
- R10: While `rst_n` is low, both requests are 0 after each clock edge.
- R11: A clear strobe for one direction does not affect the request of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en_i | input | 1 | FIFO enable control bit |
| dma_mode_i | input | 1 | DMA mode select control bit |
| rx_trig_sel_i | input | 2 | Receive trigger-level code |
| rx_level_i | input | 5 | Receive FIFO fill level, 0 to 16 |
| rx_timeout_i | input | 1 | Character time-out pulse |
| tx_full_i | input | 1 | Transmit FIFO full flag |
| rx_dma_clr_i | input | 1 | Receive request clear strobe from the DMA controller |
| tx_dma_clr_i | input | 1 | Transmit request clear strobe from the DMA controller |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_data_avail_o | output | 1 | Receive data-available interrupt condition |

## Verification
The assertions assume the following about the inputs:
- `rx_level_i` never exceeds the FIFO depth of 16.
- `tx_full_i` is held low during reset, so the first sample after reset cannot show a spurious falling edge.
- Time-out and clear strobes are synchronous pulses, sampled only at the clock edge.

The stimulus drives every input just after the falling clock edge and keeps the level between 0 and 16. It holds the full flag low through reset and raises it only while the block is running.

// File: rtl/uart_dma_pkg.sv
// Package: shared sizing and the receive-threshold decode for the UART DMA
// request generator. Assumes the FIFO depth is a multiple of 4 and at least 4.
package uart_dma_pkg;

    localparam int unsigned UDR_DEPTH = 16;
    localparam int unsigned UDR_LVL_W = $clog2(UDR_DEPTH + 1);

    // Trigger code to threshold: 0 -> 1, 1 -> depth/4, 2 -> depth/2, 3 -> depth-2.
    function automatic int unsigned udr_threshold(input logic [1:0] code,
                                                  input int unsigned depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/udr_trig_decode.sv
// Module: udr_trig_decode
// Decodes the 2-bit receive trigger code into a character threshold and
// compares the receive FIFO level against it. The result is combinational and
// is gated by FIFO enable. Assumes the level never exceeds DEPTH.
module udr_trig_decode
    import uart_dma_pkg::*;
#(
    parameter int unsigned DEPTH = UDR_DEPTH,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en_i,
    input  logic [1:0]    code_i,
    input  logic [LW-1:0] level_i,
    output logic          met_o
);

    logic [LW-1:0] thr;

    // Threshold lookup and compare.
    always_comb begin
        thr   = LW'(udr_threshold(code_i, DEPTH));
        met_o = fifo_en_i && (level_i >= thr);
    end

    // R1: a full FIFO meets every threshold.
    p_full_meets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_i && level_i == LW'(DEPTH)) |-> met_o);

    // R1: an empty FIFO meets no threshold.
    p_empty_never_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == '0) |-> !met_o);

endmodule

// File: rtl/udr_req_flop.sv
// Module: udr_req_flop
// One sticky request bit. Set has priority over clear, and a low enable
// forces the bit to 0. The reset is synchronous and active low.
// Assumes set and clr are synchronous single-cycle or level signals.
module udr_req_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o
);

    // Request state update: kill, then set, then clear, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       req_o <= 1'b0;
        else if (!en_i)   req_o <= 1'b0;
        else if (set_i)   req_o <= 1'b1;
        else if (clr_i)   req_o <= 1'b0;
    end

    // R8: a set in the same cycle as a clear leaves the request high.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && set_i && clr_i) |=> req_o);

    // R6: without a clear the request holds.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && req_o && !clr_i) |=> req_o);

    // R7: a clear with no set drops the request.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clr_i && !set_i) |=> !req_o);

    // R9: disable forces the request low.
    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !req_o);

endmodule

// File: rtl/udr_tx_edge.sv
// Module: udr_tx_edge
// Detects the cycle where the transmit FIFO full flag falls. The previous
// flag value is kept without reset, so the detector is always in step with
// the input. Assumes the flag is held low during reset.
module udr_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic full_i,
    output logic fall_o
);

    logic full_q;

    // Keep the flag value from the previous cycle.
    always_ff @(posedge clk) begin
        full_q <= full_i;
    end

    // A falling edge is the previous value 1 with the current value 0.
    always_comb begin
        fall_o = full_q && !full_i;
    end

    // R5: no falling edge is reported while the flag is high.
    p_no_edge_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full_i |-> !fall_o);

endmodule

// File: rtl/uart_dma_req_gen.sv
// Module: uart_dma_req_gen (top)
// Produces the receive and transmit DMA requests for a UART with FIFOs.
// - Receive request: set by a threshold crossing or a time-out.
// - Transmit request: set when the transmit FIFO leaves the full state.
// - Both requests: cleared only by their DMA clear strobes, and gated by
//   FIFO enable and DMA mode.
// Assumes all inputs are synchronous to clk and the level is at most DEPTH.
module uart_dma_req_gen
    import uart_dma_pkg::*;
#(
    parameter int unsigned DEPTH = UDR_DEPTH,
    localparam int unsigned LW   = $clog2(DEPTH + 1),
    localparam int unsigned NDIR = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en_i,
    input  logic          dma_mode_i,
    input  logic [1:0]    rx_trig_sel_i,
    input  logic [LW-1:0] rx_level_i,
    input  logic          rx_timeout_i,
    input  logic          tx_full_i,
    input  logic          rx_dma_clr_i,
    input  logic          tx_dma_clr_i,
    output logic          rx_dma_req_o,
    output logic          tx_dma_req_o,
    output logic          rx_data_avail_o
);

    localparam int unsigned DIR_RX = 0;
    localparam int unsigned DIR_TX = 1;

    logic            dma_en;
    logic            tx_fall;
    logic [NDIR-1:0] set_v;
    logic [NDIR-1:0] clr_v;
    logic [NDIR-1:0] req_v;

    udr_trig_decode #(.DEPTH(DEPTH)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en_i (fifo_en_i),
        .code_i    (rx_trig_sel_i),
        .level_i   (rx_level_i),
        .met_o     (rx_data_avail_o)
    );

    udr_tx_edge u_tx_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .full_i (tx_full_i),
        .fall_o (tx_fall)
    );

    // Combine the control bits and collect the set and clear terms per direction.
    always_comb begin
        dma_en        = fifo_en_i && dma_mode_i;
        set_v[DIR_RX] = rx_data_avail_o || rx_timeout_i;
        set_v[DIR_TX] = tx_fall;
        clr_v[DIR_RX] = rx_dma_clr_i;
        clr_v[DIR_TX] = tx_dma_clr_i;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        udr_req_flop u_req (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (dma_en),
            .set_i (set_v[d]),
            .clr_i (clr_v[d]),
            .req_o (req_v[d])
        );
    end

    assign rx_dma_req_o = req_v[DIR_RX];
    assign tx_dma_req_o = req_v[DIR_TX];

    // R2: a met threshold raises the receive request.
    p_thresh_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && rx_data_avail_o) |=> rx_dma_req_o);

    // R3: a time-out raises the receive request.
    p_timeout_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && rx_timeout_i) |=> rx_dma_req_o);

    // R4: the full flag falling raises the transmit request.
    p_tx_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && $fell(tx_full_i)) |=> tx_dma_req_o);

    // R5: with no falling edge, a low transmit request stays low.
    p_tx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(tx_full_i) && !tx_dma_req_o) |=> !tx_dma_req_o);

    // R10: reset clears both requests.
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!rx_dma_req_o && !tx_dma_req_o));

endmodule

// File: tb/tb_uart_dma_req_gen.sv
// Directed bench for uart_dma_req_gen.
// Inputs change just after the falling edge. Outputs are checked at the
// following falling edge, after one rising edge has updated the registers.
module tb_uart_dma_req_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en, dma_mode, rx_timeout, tx_full, rx_clr, tx_clr;
    logic [1:0] trig;
    logic [4:0] level;
    logic       rx_req, tx_req, rx_avail;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_dma_req_gen dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .fifo_en_i       (fifo_en),
        .dma_mode_i      (dma_mode),
        .rx_trig_sel_i   (trig),
        .rx_level_i      (level),
        .rx_timeout_i    (rx_timeout),
        .tx_full_i       (tx_full),
        .rx_dma_clr_i    (rx_clr),
        .tx_dma_clr_i    (tx_clr),
        .rx_dma_req_o    (rx_req),
        .tx_dma_req_o    (tx_req),
        .rx_data_avail_o (rx_avail)
    );

    // Compare one value and count the result.
    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Pulse the receive clear strobe with the level at 0.
    task automatic clear_rx();
        level  = 5'd0;
        rx_clr = 1'b1;
        tick();
        rx_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; fifo_en = 1'b1; dma_mode = 1'b1; trig = 2'd0;
        level = 5'd16; rx_timeout = 1'b1; tx_full = 1'b0;
        rx_clr = 1'b0; tx_clr = 1'b0;
        tick(); tick();
        check("R10 rx in reset", rx_req, 1'b0);
        check("R10 tx in reset", tx_req, 1'b0);
        rx_timeout = 1'b0; level = 5'd0; fifo_en = 1'b0; dma_mode = 1'b0;
        rst_n = 1'b1;
        tick();
    endtask

    // Check the decode at each code, just below and at the threshold.
    task automatic t_decode();
        int thr[4] = '{1, 4, 8, 14};
        fifo_en = 1'b1; dma_mode = 1'b0;
        for (int c = 0; c < 4; c++) begin
            trig  = c[1:0];
            level = 5'(thr[c] - 1);
            #1 check("R1 below threshold", rx_avail, 1'b0);
            level = 5'(thr[c]);
            #1 check("R1 at threshold", rx_avail, 1'b1);
        end
        level = 5'd16;
        #1 check("R1 full level", rx_avail, 1'b1);
        tick();
        check("R9 dma mode off, no rx request", rx_req, 1'b0);
        fifo_en = 1'b0;
        #1 check("R1 fifo disabled", rx_avail, 1'b0);
        level = 5'd0;
        tick();
    endtask

    task automatic t_rx_thresh();
        fifo_en = 1'b1; dma_mode = 1'b1; trig = 2'd1; level = 5'd3;
        tick();
        check("R2 level 3 below 4", rx_req, 1'b0);
        level = 5'd4;
        tick();
        check("R2 level 4 meets 4", rx_req, 1'b1);
        level = 5'd1;
        tick();
        check("R6 held after level drop", rx_req, 1'b1);
        clear_rx();
        check("R7 rx clear", rx_req, 1'b0);
    endtask

    task automatic t_timeout();
        trig = 2'd3; level = 5'd2; rx_timeout = 1'b1;
        tick();
        rx_timeout = 1'b0;
        check("R3 timeout sets", rx_req, 1'b1);
        tick(); tick();
        check("R6 timeout request held", rx_req, 1'b1);
        clear_rx();
        check("R7 clear after timeout", rx_req, 1'b0);
    endtask

    task automatic t_tx();
        tx_full = 1'b0;
        tick(); tick();
        check("R5 steady not full", tx_req, 1'b0);
        tx_full = 1'b1;
        tick();
        check("R5 rising full", tx_req, 1'b0);
        tick();
        check("R5 steady full", tx_req, 1'b0);
        tx_full = 1'b0;
        tick();
        check("R4 full falls", tx_req, 1'b1);
        tick(); tick();
        check("R6 tx held", tx_req, 1'b1);
        // Raise rx too, then clear only tx.
        rx_timeout = 1'b1;
        tick();
        rx_timeout = 1'b0;
        tx_clr = 1'b1;
        tick();
        tx_clr = 1'b0;
        check("R7 tx clear", tx_req, 1'b0);
        check("R11 rx kept on tx clear", rx_req, 1'b1);
        clear_rx();
        check("R11 rx clear", rx_req, 1'b0);
    endtask

    task automatic t_set_wins();
        trig = 2'd3; level = 5'd14; rx_clr = 1'b1;
        tick();
        check("R8 set beats clear", rx_req, 1'b1);
        rx_clr = 1'b0;
        clear_rx();
        check("R7 clear after set-wins", rx_req, 1'b0);
    endtask

    task automatic t_gate();
        trig = 2'd0; level = 5'd1;
        tx_full = 1'b1; tick();
        tx_full = 1'b0; tick();
        check("R9 setup rx", rx_req, 1'b1);
        check("R9 setup tx", tx_req, 1'b1);
        level = 5'd0; dma_mode = 1'b0;
        tick();
        check("R9 dma off rx", rx_req, 1'b0);
        check("R9 dma off tx", tx_req, 1'b0);
        dma_mode = 1'b1;
        tick();
        check("R9 rx not restored", rx_req, 1'b0);
        check("R9 tx not restored", tx_req, 1'b0);
        fifo_en = 1'b0; level = 5'd16;
        tick();
        check("R9 fifo off, no rx request", rx_req, 1'b0);
        level = 5'd0; fifo_en = 1'b1;
        tick();
    endtask

    initial begin
        t_reset();
        t_decode();
        t_rx_thresh();
        t_timeout();
        t_tx();
        t_set_wins();
        t_gate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule